// File: doc/BRIEF.md
# Peripheral clock-gate and reset sequencer

This block is a register-mapped controller that switches the clocks of up to sixteen peripheral modules per register group and holds those modules in or out of reset. Software reaches it through a plain 32-bit read/write port. Every control write carries a write-enable mask in its upper half-word. A lower data bit changes only where its mask bit is set, so one module can be switched without a read-modify-write. Gated clocks leave the block as per-module enable levels. Resets leave it as per-module active-low outputs.

Each group has four registers. Clock control sits at 0x500 + 4g and clock monitor at 0x680 + 4g. Reset control sits at 0x800 + 4g and reset monitor at 0x980 + 4g. Module m of group g owns bit m of each of them. A clock monitor bit confirms the gate change after a fixed two-cycle synchroniser delay.

Reset changes are timed by `ref_tick`. This input is a one-cycle pulse in the `clk` domain that marks each edge of a slow reference clock (about 32 kHz). Each module has its own sequencer with these states:
- RS_RUN: released.
- RS_ARM: reset requested, waiting for a tick.
- RS_HOLD: in reset, minimum interval still running.
- RS_HELD: in reset, minimum interval met.
- RS_LEAVE: release requested, waiting for a tick.

The transitions are:
- RUN→ARM when the control bit reads 0.
- ARM→RUN when the request is withdrawn before a tick.
- ARM→HOLD on a tick.
- HOLD→RUN on the next tick if release is requested by then, otherwise HOLD→HELD on that tick.
- HELD→LEAVE on a release request.
- LEAVE→HELD if the request is withdrawn.
- LEAVE→RUN on a tick.

Top module: `modgate_rstctl`

## Requirements
- R1: A write to a control register updates lower bit n only when bit n+16 of the write data is 1. Every other lower bit keeps its value.
- R2: `mod_clk_en[16g+m]` equals bit m of clock control register g (1 = clock running). It changes only on the clock edge that takes a write.
- R3: A control register reads back its 16 state bits in [15:0], with [31:16] reading 0.
- R4: A clock monitor bit equals its clock enable delayed by exactly two `clk` cycles. A read whose request is sampled at edge P+3 after a write at edge P shows the new value, and one sampled at P+2 still shows the old value.
- R5: A reset control data bit of 0 requests reset and 1 requests release. `mod_rst_n` changes only on the edge that samples `ref_tick` high. A request withdrawn before that tick produces no reset pulse.
- R6: Once a module's reset output is low, it stays low until a later tick, even if release was requested in between. Low time is at least one full tick interval.
- R7: A reset monitor bit equals `mod_rst_n` registered once (1 = released). A read sampled one edge after the tick shows the old value, and a read sampled two edges after shows the new value.
- R8: After `rst_n`, modules whose bit is set in `CRIT_MASK` have clock on and reset released. All others have clock off and are held in reset. Both control registers hold `CRIT_MASK`.
- R9: Monitor registers are read-only, and writes to them change nothing.
- R10: Reads of unmapped or unaligned offsets return 0, and writes to them change nothing.
- R11: `rdata` carries the word addressed on the edge where `rd_en` was sampled and is 0 in any cycle after a non-read edge. A read and a write to the same register on one edge return the old value.
- R12: A reset control write taken on the same edge as a tick is first acted on at the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ref_tick | input | 1 | One-cycle pulse marking a slow reference clock edge |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data: [31:16] mask, [15:0] data |
| rdata | output | 32 | Registered read data |
| mod_clk_en | output | 16*NUM_GROUPS | Per-module clock enable |
| mod_rst_n | output | 16*NUM_GROUPS | Per-module active-low reset |

## Verification
Two pairs of events can land on the same edge.

The first pair is a reset control write and a `ref_tick`. The bench drives the release write and the tick on one edge. It then requires the reset output to stay low through several idle cycles and to rise only after the next tick.

The second pair is a read and a write to the same clock control register. The bench issues both on one edge. It requires the scoreboard to receive the pre-write value, a following read to show the merged value, and the enables to match it.

// File: rtl/mgr_pkg.sv
package mgr_pkg;
    localparam int ADDR_W        = 12;
    localparam int GATES_PER_REG = 16;
    localparam int MON_STAGES    = 2;

    localparam logic [ADDR_W-1:0] CLK_CTRL_BASE = 12'h500;
    localparam logic [ADDR_W-1:0] CLK_MON_BASE  = 12'h680;
    localparam logic [ADDR_W-1:0] RST_CTRL_BASE = 12'h800;
    localparam logic [ADDR_W-1:0] RST_MON_BASE  = 12'h980;

    typedef enum logic [2:0] {
        RS_RUN,
        RS_ARM,
        RS_HOLD,
        RS_HELD,
        RS_LEAVE
    } rs_state_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CLK_CTRL,
        RG_CLK_MON,
        RG_RST_CTRL,
        RG_RST_MON
    } reg_grp_e;

    // upper half of the write word enables the matching lower bit
    function automatic logic [GATES_PER_REG-1:0] masked_merge(
        input logic [GATES_PER_REG-1:0]   cur,
        input logic [2*GATES_PER_REG-1:0] wd
    );
        logic [GATES_PER_REG-1:0] m;
        m = wd[2*GATES_PER_REG-1:GATES_PER_REG];
        return (cur & ~m) | (wd[GATES_PER_REG-1:0] & m);
    endfunction
endpackage

// File: rtl/mgr_addr_dec.sv
module mgr_addr_dec
    import mgr_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    localparam int IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_grp_e          grp,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        grp = RG_NONE;
        idx = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (addr == CLK_CTRL_BASE + ADDR_W'(4 * g)) begin
                grp = RG_CLK_CTRL;
                idx = IDX_W'(g);
            end
            if (addr == CLK_MON_BASE + ADDR_W'(4 * g)) begin
                grp = RG_CLK_MON;
                idx = IDX_W'(g);
            end
            if (addr == RST_CTRL_BASE + ADDR_W'(4 * g)) begin
                grp = RG_RST_CTRL;
                idx = IDX_W'(g);
            end
            if (addr == RST_MON_BASE + ADDR_W'(4 * g)) begin
                grp = RG_RST_MON;
                idx = IDX_W'(g);
            end
        end
    end
endmodule

// File: rtl/mgr_regbank.sv
module mgr_regbank
    import mgr_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter logic [GATES_PER_REG*NUM_GROUPS-1:0] CRIT_MASK = '0,
    localparam int NMOD  = GATES_PER_REG * NUM_GROUPS,
    localparam int IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [NMOD-1:0]   clk_mon,
    input  logic [NMOD-1:0]   rst_mon,
    output logic [NMOD-1:0]   clk_ctrl,
    output logic [NMOD-1:0]   rst_ctrl,
    output logic [31:0]       rdata
);
    reg_grp_e         sel_grp;
    logic [IDX_W-1:0] sel_idx;
    logic [NMOD-1:0]  clk_ctrl_q;
    logic [NMOD-1:0]  rst_ctrl_q;
    logic [31:0]      rd_word;
    logic [31:0]      rdata_q;

    mgr_addr_dec #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
        .addr (addr),
        .grp  (sel_grp),
        .idx  (sel_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_ctrl_q <= CRIT_MASK;
            rst_ctrl_q <= CRIT_MASK;
        end else if (wr_en) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (sel_idx == IDX_W'(g)) begin
                    if (sel_grp == RG_CLK_CTRL)
                        clk_ctrl_q[g*GATES_PER_REG +: GATES_PER_REG] <=
                            masked_merge(clk_ctrl_q[g*GATES_PER_REG +: GATES_PER_REG], wdata);
                    if (sel_grp == RG_RST_CTRL)
                        rst_ctrl_q[g*GATES_PER_REG +: GATES_PER_REG] <=
                            masked_merge(rst_ctrl_q[g*GATES_PER_REG +: GATES_PER_REG], wdata);
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (sel_grp)
            RG_CLK_CTRL: rd_word = {16'h0, clk_ctrl_q[int'(sel_idx)*GATES_PER_REG +: GATES_PER_REG]};
            RG_CLK_MON:  rd_word = {16'h0, clk_mon[int'(sel_idx)*GATES_PER_REG +: GATES_PER_REG]};
            RG_RST_CTRL: rd_word = {16'h0, rst_ctrl_q[int'(sel_idx)*GATES_PER_REG +: GATES_PER_REG]};
            RG_RST_MON:  rd_word = {16'h0, rst_mon[int'(sel_idx)*GATES_PER_REG +: GATES_PER_REG]};
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_en ? rd_word : '0;
    end

    assign clk_ctrl = clk_ctrl_q;
    assign rst_ctrl = rst_ctrl_q;
    assign rdata    = rdata_q;
endmodule

// File: rtl/mgr_clk_sync.sv
module mgr_clk_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RESET_VAL;
            else if (s == 0) stage_q[s] <= d;
            else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mgr_rst_seq.sv
module mgr_rst_seq
    import mgr_pkg::*;
#(
    parameter logic START_RUN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run_req,
    output logic mod_rst_n
);
    rs_state_e state_q;
    rs_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= START_RUN ? RS_RUN : RS_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_RUN:   if (!run_req) state_d = RS_ARM;
            RS_ARM: begin
                if (run_req)   state_d = RS_RUN;
                else if (tick) state_d = RS_HOLD;
            end
            RS_HOLD:  if (tick) state_d = run_req ? RS_RUN : RS_HELD;
            RS_HELD:  if (run_req) state_d = RS_LEAVE;
            RS_LEAVE: begin
                if (!run_req)  state_d = RS_HELD;
                else if (tick) state_d = RS_RUN;
            end
            default:  state_d = RS_HELD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RS_RUN, RS_ARM: mod_rst_n = 1'b1;
            default:        mod_rst_n = 1'b0;
        endcase
    end
endmodule

// File: rtl/modgate_rstctl.sv
module modgate_rstctl
    import mgr_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter logic [16*NUM_GROUPS-1:0] CRIT_MASK = 32'h0008_0001
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_tick,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [11:0]             addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    output logic [16*NUM_GROUPS-1:0] mod_clk_en,
    output logic [16*NUM_GROUPS-1:0] mod_rst_n
);
    localparam int NMOD = GATES_PER_REG * NUM_GROUPS;

    logic [NMOD-1:0] clk_ctrl;
    logic [NMOD-1:0] rst_ctrl;
    logic [NMOD-1:0] clk_mon;
    logic [NMOD-1:0] rst_mon;

    mgr_regbank #(.NUM_GROUPS(NUM_GROUPS), .CRIT_MASK(CRIT_MASK)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .clk_mon  (clk_mon),
        .rst_mon  (rst_mon),
        .clk_ctrl (clk_ctrl),
        .rst_ctrl (rst_ctrl),
        .rdata    (rdata)
    );

    mgr_clk_sync #(.WIDTH(NMOD), .STAGES(MON_STAGES), .RESET_VAL(CRIT_MASK)) u_clk_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (clk_ctrl),
        .q     (clk_mon)
    );

    for (genvar i = 0; i < NMOD; i++) begin : g_seq
        mgr_rst_seq #(.START_RUN(CRIT_MASK[i])) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (ref_tick),
            .run_req   (rst_ctrl[i]),
            .mod_rst_n (mod_rst_n[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_mon <= CRIT_MASK;
        else        rst_mon <= mod_rst_n;
    end

    assign mod_clk_en = clk_ctrl;
endmodule

// File: rtl/mgr_checker.sv
module mgr_checker #(
    parameter int NMOD = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ref_tick,
    input logic            wr_en,
    input logic            rd_en,
    input logic [31:0]     rdata,
    input logic [NMOD-1:0] mod_clk_en,
    input logic [NMOD-1:0] mod_rst_n,
    input logic [NMOD-1:0] clk_mon,
    input logic [NMOD-1:0] rst_mon
);
    // R2
    clken_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(mod_clk_en))
        else $error("clock enables moved without a write");

    // R4
    clkmon_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_mon == $past(mod_clk_en, 2))
        else $error("clock monitor not two cycles behind enable");

    // R5
    rst_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_rst_n != $past(mod_rst_n)) |-> $past(ref_tick))
        else $error("reset output changed without a tick");

    // R7
    rstmon_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_mon == $past(mod_rst_n))
        else $error("reset monitor not one cycle behind output");

    // R11
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rdata == 32'h0))
        else $error("read data nonzero after idle edge");

    for (genvar i = 0; i < NMOD; i++) begin : g_hold
        // R6
        rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mod_rst_n[i] && !ref_tick) |=> !mod_rst_n[i])
            else $error("reset released without a tick");
    end
endmodule

bind modgate_rstctl mgr_checker #(.NMOD(NMOD)) u_mgr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick   (ref_tick),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .mod_clk_en (mod_clk_en),
    .mod_rst_n  (mod_rst_n),
    .clk_mon    (clk_mon),
    .rst_mon    (rst_mon)
);

// File: tb/tb_modgate_rstctl.sv
module tb_modgate_rstctl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] mod_clk_en;
    logic [31:0] mod_rst_n;

    int n_chk = 0;
    int n_fail = 0;
    logic rd_d = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    modgate_rstctl #(.NUM_GROUPS(2), .CRIT_MASK(32'h0008_0001)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .mod_clk_en (mod_clk_en),
        .mod_rst_n  (mod_rst_n)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: one read result per sampled read request
    always @(posedge clk) rd_d <= rd_en;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                chk(rdata, 32'hxxxx_xxxx, "R11 unexpected read");
            end else begin
                chk(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic drive(input logic w, input logic r, input logic t,
                         input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; ref_tick = t; addr = a; wdata = d;
        @(posedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        drive(1'b1, 1'b0, 1'b0, a, d);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        drive(1'b0, 1'b1, 1'b0, a, 32'h0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 1'b0, 12'h0, 32'h0);
    endtask

    task automatic tick();
        drive(1'b0, 1'b0, 1'b1, 12'h0, 32'h0);
    endtask

    task automatic at_neg_chk(input logic [31:0] act_sel, input logic [31:0] exp, input string tag);
        chk(act_sel, exp, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_P * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8 power-on outputs while reset is held
        chk(mod_clk_en, 32'h0008_0001, "R8 clock enables at reset");
        chk(mod_rst_n,  32'h0008_0001, "R8 reset outputs at reset");
        rst_n = 1'b1;
        idle(2);

        // R8 / R3 / R7 / R4 power-on register contents
        rd(12'h500, 32'h0000_0001, "R8 R3 clock ctrl g0");
        rd(12'h504, 32'h0000_0008, "R8 R3 clock ctrl g1");
        rd(12'h800, 32'h0000_0001, "R8 reset ctrl g0");
        rd(12'h984, 32'h0000_0008, "R7 R8 reset mon g1");
        rd(12'h684, 32'h0000_0008, "R4 R8 clock mon g1");
        idle(1);

        // R1 masked write then R4 exact monitor delay
        wr(12'h500, 32'h0003_0006);
        rd(12'h680, 32'h0000_0001, "R4 monitor old at P+1");
        rd(12'h680, 32'h0000_0001, "R4 monitor old at P+2");
        rd(12'h680, 32'h0000_0002, "R4 monitor new at P+3");
        idle(1);
        @(negedge clk);
        chk(mod_clk_en, 32'h0008_0002, "R2 enables follow masked write");
        rd(12'h500, 32'h0000_0002, "R1 R3 masked merge readback");
        wr(12'h500, 32'h8000_FFFF);
        rd(12'h500, 32'h0000_8002, "R1 only masked bit changes");
        idle(1);
        @(negedge clk);
        chk(mod_clk_en, 32'h0008_8002, "R2 single bit enable");

        // R9 monitor writes ignored
        wr(12'h680, 32'hFFFF_FFFF);
        wr(12'h980, 32'hFFFF_0000);
        idle(3);
        rd(12'h680, 32'h0000_8002, "R9 clock mon unchanged");
        rd(12'h980, 32'h0000_0001, "R9 reset mon unchanged");
        idle(1);
        @(negedge clk);
        chk(mod_rst_n, 32'h0008_0001, "R9 reset outputs unchanged");

        // R10 unmapped and unaligned
        wr(12'h508, 32'hFFFF_FFFF);
        wr(12'h502, 32'hFFFF_FFFF);
        rd(12'h500, 32'h0000_8002, "R10 unaligned write ignored");
        rd(12'h508, 32'h0000_0000, "R10 unmapped read zero");
        rd(12'h000, 32'h0000_0000, "R10 offset zero read");
        rd(12'h688, 32'h0000_0000, "R10 monitor beyond groups");
        idle(1);
        @(negedge clk);
        chk(mod_clk_en, 32'h0008_8002, "R10 enables unchanged");

        // R5 release waits for tick, R7 monitor timing
        wr(12'h800, 32'h0002_0002);
        idle(3);
        @(negedge clk);
        chk(mod_rst_n, 32'h0008_0001, "R5 no release before tick");
        tick();
        rd(12'h980, 32'h0000_0001, "R7 reset mon old one edge after");
        rd(12'h980, 32'h0000_0003, "R7 reset mon new two edges after");
        idle(1);
        @(negedge clk);
        chk(mod_rst_n, 32'h0008_0003, "R5 release on tick");

        // R5 assert on tick, R6 minimum hold
        wr(12'h800, 32'h0002_0000);
        idle(2);
        @(negedge clk);
        chk(mod_rst_n, 32'h0008_0003, "R5 no assert before tick");
        tick();
        idle(1);
        @(negedge clk);
        chk(mod_rst_n, 32'h0008_0001, "R5 assert on tick");
        wr(12'h800, 32'h0002_0002);
        idle(4);
        @(negedge clk);
        chk(mod_rst_n, 32'h0008_0001, "R6 held until next tick");
        tick();
        idle(1);
        @(negedge clk);
        chk(mod_rst_n, 32'h0008_0003, "R6 released after one interval");

        // R5 withdrawn request gives no pulse
        wr(12'h800, 32'h0002_0000);
        wr(12'h800, 32'h0002_0002);
        tick();
        idle(1);
        @(negedge clk);
        chk(mod_rst_n, 32'h0008_0003, "R5 withdrawn request no pulse");

        // R12 write and tick on the same edge
        drive(1'b1, 1'b0, 1'b1, 12'h800, 32'h0004_0004);
        idle(3);
        @(negedge clk);
        chk(mod_rst_n, 32'h0008_0003, "R12 coincident tick not used");
        tick();
        idle(1);
        @(negedge clk);
        chk(mod_rst_n, 32'h0008_0007, "R12 released on following tick");
        wr(12'h804, 32'h0001_0001);
        idle(1);
        tick();
        idle(2);
        @(negedge clk);
        chk(mod_rst_n, 32'h0009_0007, "R5 second group release");
        rd(12'h984, 32'h0000_0009, "R7 reset mon g1");
        rd(12'h800, 32'h0000_0007, "R3 reset ctrl g0");

        // R11 read and write on one edge
        exp_q.push_back(32'h0000_0008);
        tag_q.push_back("R11 same-edge read returns old");
        drive(1'b1, 1'b1, 1'b0, 12'h504, 32'hFFFF_0001);
        rd(12'h504, 32'h0000_0001, "R11 following read returns new");
        idle(2);
        @(negedge clk);
        chk(mod_clk_en, 32'h0001_8002, "R2 R11 enables after merged write");
        chk(rdata, 32'h0000_0000, "R11 rdata zero when idle");

        idle(3);
        if (exp_q.size() != 0) chk(32'(exp_q.size()), 32'h0, "R11 reads left unanswered");
        summary();
        $finish;
    end
endmodule